// File: doc/BRIEF.md
# Incremental Ones-Count Tracker

This block is a serial-in shift register that also reports how many of its bits are set. It does not sum every bit of the register each cycle. It keeps a separate up/down counter and moves it by at most one step per shift. The step depends only on two bits: the bit entering the register and the bit falling off its far end. As a result, the logic between registers stays shallow however deep the register grows, which suits designs clocked near 1 GHz.

A client presents a data bit together with a shift enable. The new bit enters at position 0, and every stored bit moves up by one position. The bit at position DEPTH-1 leaves the register. A synchronous clear empties the register and zeroes the count together. Both outputs are registered and always agree with each other.

Top module: `ones_tracker`

## Requirements
- R1: While the active-low asynchronous reset is asserted, and in the cycle after it is released, the register contents and the ones count are both zero.
- R2: On a clock edge with shift enable high and clear low, the register becomes its old contents shifted one position toward the MSB, with the data bit placed in bit 0. The old bit DEPTH-1 is discarded.
- R3: On such a shift, when the data bit equals the old bit DEPTH-1, the ones count keeps its value.
- R4: On such a shift, when the data bit is 1 and the old bit DEPTH-1 is 0, the ones count rises by exactly one.
- R5: On such a shift, when the data bit is 0 and the old bit DEPTH-1 is 1, the ones count falls by exactly one.
- R6: On a clock edge with clear high, the register and the count both become zero, whatever the shift enable and data bit are. Clear has priority over shift.
- R7: On a clock edge with shift enable and clear both low, the register and the count keep their values, whatever the data bit is.
- R8: In every cycle, the ones count equals the number of set bits on the register output.
- R9: The count port is clog2(DEPTH+1) bits wide. It reaches exactly DEPTH when the register is full of ones, and it never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Shift strobe for this cycle |
| clear | input | 1 | Synchronous clear of register and count |
| din | input | 1 | Serial data bit, enters at bit 0 |
| shreg_q | output | DEPTH | Register contents |
| ones_cnt | output | CNT_W | Number of set bits in shreg_q |

## Verification
The step properties rely on the inputs being known (0 or 1) at every sampled edge. They also rely on the first sampled edge after reset having a defined previous cycle; the checker guards this with its own flag. The bench always drives the inputs to known levels from a negative clock edge onward, so no property ever sees an undefined value. The stimulus fills the register with ones and empties it again to reach both ends of the count range. It runs a long pseudo-random sequence in which clear is sometimes raised together with shift enable.

// File: rtl/ones_trk_pkg.sv
package ones_trk_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/ones_shreg.sv
module ones_shreg #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             clear,
  input  logic             din,
  output logic [DEPTH-1:0] q,
  output logic             tail
);
  logic [DEPTH-1:0] shifted;
  logic [DEPTH-1:0] q_nxt;

  generate
    if (DEPTH == 1) begin : g_single
      assign shifted = din;
    end else begin : g_multi
      assign shifted = {q[DEPTH-2:0], din};
    end
  endgenerate

  always_comb begin
    q_nxt = q;
    if (clear)         q_nxt = '0;
    else if (shift_en) q_nxt = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign tail = q[DEPTH-1];
endmodule

// File: rtl/ones_step_dec.sv
module ones_step_dec
  import ones_trk_pkg::*;
(
  input  logic  shift_en,
  input  logic  din,
  input  logic  tail,
  output step_e step
);
  always_comb begin
    step = STEP_HOLD;
    if (shift_en && (din != tail)) begin
      step = din ? STEP_UP : STEP_DOWN;
    end
  end
endmodule

// File: rtl/ones_updn_cnt.sv
module ones_updn_cnt
  import ones_trk_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  step_e            step,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (clear) begin
      cnt_nxt = '0;
    end else begin
      unique case (step)
        STEP_UP:   cnt_nxt = cnt + CNT_W'(1);
        STEP_DOWN: cnt_nxt = cnt - CNT_W'(1);
        default:   cnt_nxt = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/ones_tracker.sv
module ones_tracker
  import ones_trk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             clear,
  input  logic             din,
  output logic [DEPTH-1:0] shreg_q,
  output logic [CNT_W-1:0] ones_cnt
);
  logic  tail;
  step_e step;

  ones_shreg #(.DEPTH(DEPTH)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .clear    (clear),
    .din      (din),
    .q        (shreg_q),
    .tail     (tail)
  );

  ones_step_dec u_dec (
    .shift_en (shift_en),
    .din      (din),
    .tail     (tail),
    .step     (step)
  );

  ones_updn_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (step),
    .cnt   (ones_cnt)
  );
endmodule

// File: rtl/ones_tracker_chk.sv
module ones_tracker_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             clear,
  input logic             din,
  input logic [DEPTH-1:0] shreg_q,
  input logic [CNT_W-1:0] ones_cnt
);
  logic past_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_vld <= 1'b0;
    else        past_vld <= 1'b1;
  end

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (shreg_q == '0 && ones_cnt == '0);
    end
  end

  a_r8_cnt_matches: assert property (@(posedge clk) disable iff (!rst_n)
    past_vld |-> (CNT_W'($countones(shreg_q)) == ones_cnt));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    past_vld |-> (int'(ones_cnt) <= DEPTH));

  a_r3_equal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (past_vld && shift_en && !clear && (din == shreg_q[DEPTH-1]))
      |=> (ones_cnt == $past(ones_cnt)));

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (past_vld && shift_en && !clear && din && !shreg_q[DEPTH-1])
      |=> (ones_cnt == $past(ones_cnt) + CNT_W'(1)));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (past_vld && shift_en && !clear && !din && shreg_q[DEPTH-1])
      |=> (ones_cnt == $past(ones_cnt) - CNT_W'(1)));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (past_vld && clear) |=> (shreg_q == '0 && ones_cnt == '0));

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (past_vld && !shift_en && !clear) |=> ($stable(shreg_q) && $stable(ones_cnt)));

  a_r2_bit0_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (past_vld && shift_en && !clear) |=> (shreg_q[0] == $past(din)));
endmodule

bind ones_tracker ones_tracker_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_en (shift_en),
  .clear    (clear),
  .din      (din),
  .shreg_q  (shreg_q),
  .ones_cnt (ones_cnt)
);

// File: tb/ones_tracker_tb.sv
module ones_tracker_tb;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk;
  logic             rst_n;
  logic             shift_en;
  logic             clear;
  logic             din;
  logic [DEPTH-1:0] shreg_q;
  logic [CNT_W-1:0] ones_cnt;

  typedef struct {
    logic [DEPTH-1:0] q;
    logic [CNT_W-1:0] c;
    string            req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  logic [DEPTH-1:0] mdl_q;
  logic [15:0]      lfsr;

  ones_tracker #(.DEPTH(DEPTH)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .clear    (clear),
    .din      (din),
    .shreg_q  (shreg_q),
    .ones_cnt (ones_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [CNT_W-1:0] pop(input logic [DEPTH-1:0] v);
    int n = 0;
    for (int i = 0; i < DEPTH; i++) n += int'(v[i]);
    return CNT_W'(n);
  endfunction

  task automatic check(input string req, input logic [DEPTH-1:0] aq,
                       input logic [CNT_W-1:0] ac, input logic [DEPTH-1:0] eq,
                       input logic [CNT_W-1:0] ec);
    checks++;
    if (aq !== eq || ac !== ec) begin
      errors++;
      $display("FAIL %s: q=%h cnt=%0d expected q=%h cnt=%0d", req, aq, ac, eq, ec);
    end
  endtask

  task automatic drive(input logic en, input logic clr, input logic d);
    exp_t e;
    @(negedge clk);
    shift_en = en;
    clear    = clr;
    din      = d;
    if (clr) begin
      e.req = "R6";
      mdl_q = '0;
    end else if (!en) begin
      e.req = "R7";
    end else begin
      if (d == mdl_q[DEPTH-1]) e.req = "R3/R2";
      else if (d)              e.req = "R4/R2";
      else                     e.req = "R5/R2";
      mdl_q = {mdl_q[DEPTH-2:0], d};
    end
    e.q = mdl_q;
    e.c = pop(mdl_q);
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, shreg_q, ones_cnt, e.q, e.c);
      checks++;
      if (ones_cnt !== pop(shreg_q)) begin
        errors++;
        $display("FAIL R8: cnt=%0d expected %0d", ones_cnt, pop(shreg_q));
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; shift_en = 1'b0; clear = 1'b0; din = 1'b0;
    mdl_q = '0;
    lfsr  = 16'hACE1;
    repeat (3) @(negedge clk);
    check("R1 in reset", shreg_q, ones_cnt, '0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", shreg_q, ones_cnt, '0, '0);

    // fill with ones: R4 steps, then R3 once full
    for (int i = 0; i < DEPTH + 3; i++) drive(1'b1, 1'b0, 1'b1);
    @(negedge clk); #3;
    check("R9 full count", shreg_q, ones_cnt, {DEPTH{1'b1}}, CNT_W'(DEPTH));
    // idle with toggling data: R7
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, i[0]);
    // drain with zeros: R5
    for (int i = 0; i < DEPTH + 2; i++) drive(1'b1, 1'b0, 1'b0);
    // alternating pattern
    for (int i = 0; i < 2 * DEPTH; i++) drive(1'b1, 1'b0, i[0]);
    // clear wins over shift with din=1: R6
    drive(1'b1, 1'b1, 1'b1);
    drive(1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b0);
    // pseudo-random run
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[3] | lfsr[7], (lfsr[11:5] == 7'h15), lfsr[0]);
    end
    drive(1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule